// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block is a digital gain stage that sits on a stereo stream of 24-bit two's complement samples. The gain is a linear level, a counter between zero and unity, that moves by one step for each sample period. A sample period is marked by the input valid strobe. Every sample pair that arrives is multiplied by the gain held before that strobe, rounded, and presented one clock later with its own valid strobe.

While the mute request is high, each strobe lowers the gain toward zero, where the output is exact silence. While the request is low, each strobe raises the gain back toward unity, where samples pass through unchanged. A change of request in the middle of a ramp turns the ramp around at the level already reached. There is no restart from either end. The step size comes from the speed-mode input, so a full ramp takes the same wall time whether the stream runs at the base rate, at twice that rate, or at four times it.

A fully-muted flag tells the surrounding logic when the output has reached zero, for example so that a source can be switched without a click.

Top module: `softmute_ramp`

## Requirements
- R1: While reset is asserted and right after it, the gain is unity, `muted` is 0, `out_valid` is 0 and both outputs are 0.
- R2: The gain changes only on a clock edge where `in_valid` is 1. Mute or speed changes between strobes have no effect until the next strobe. `out_left` and `out_right` hold their values while `out_valid` is 0.
- R3: Gain runs from 0 to unity = 4096. With `speed_mode` = 0 (base rate) each strobe with `mute_req` = 1 lowers it by 4, so 1024 strobes take it from unity to zero.
- R4: With `speed_mode` = 1 the step is 2, so the ramp takes 2048 strobes. With `speed_mode` = 2 or 3 the step is 1, so it takes 4096 strobes.
- R5: Each strobe with `mute_req` = 0 raises the gain by the same step as the current speed mode.
- R6: A request change partway through a ramp reverses the direction from the level reached, with no jump.
- R7: `out_valid` follows `in_valid` one clock later. Each output equals floor((s·g + 2048) / 4096), where s is the input sample and g is the gain before that strobe.
- R8: At unity gain, samples come out bit-exact. At zero gain, both outputs are exactly 0.
- R9: `muted` is 1 exactly when the gain is zero. It changes in the clock after the strobe that moves the gain to or from zero.
- R10: The gain saturates at 0 and at unity and never wraps, including when the speed mode changes in mid-ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mute_req | input | 1 | 1 ramps the gain toward zero, 0 ramps it toward unity |
| speed_mode | input | 2 | 0 base rate, 1 double rate, 2 or 3 quad rate |
| in_valid | input | 1 | Strobe marking one sample period |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Strobe for the scaled pair |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| muted | output | 1 | Gain has reached zero |

## Verification
The bench sends full-scale positive and negative samples through every ramp, so each output shows the exact gain in force. A ramp length that is off by one strobe, or a step that is wrong for any speed mode, moves the cycle in which `muted` rises, and that is caught on the exact strobe. Early releases at a known strobe count check that a design which snapped to zero or to unity on reversal would show a jump in the output sequence. Extra strobes beyond both ends, a change of mode from quad to base near zero, and request changes between strobes expose wrap-around or updates on idle cycles. A rounding toward zero instead of toward +∞ would be seen on negative samples at partial gain.

// File: rtl/softmute_pkg.sv
package softmute_pkg;

  typedef enum logic [1:0] {
    SPD_BASE   = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_QUAD_X = 2'd3
  } speed_e;

  // Step per strobe: the base-rate step halves for every doubling of the rate.
  function automatic int unsigned ramp_step(speed_e mode, int unsigned base_step);
    case (mode)
      SPD_BASE:   return base_step;
      SPD_DOUBLE: return base_step / 2;
      default:    return base_step / 4;
    endcase
  endfunction

endpackage

// File: rtl/sm_gain_ramp.sv
module sm_gain_ramp
  import softmute_pkg::*;
#(
  parameter int FRAC_W       = 12,
  parameter int BASE_PERIODS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mute,
  input  logic [1:0]        mode,
  output logic [FRAC_W:0]   gain,
  output logic              at_zero
);
  localparam int GAIN_W = FRAC_W + 1;
  localparam int UNITY  = 1 << FRAC_W;
  localparam int BSTEP  = UNITY / BASE_PERIODS;

  logic [GAIN_W-1:0] step_amt;
  logic [GAIN_W-1:0] gain_next;
  logic [GAIN_W-1:0] headroom;

  always_comb begin
    step_amt = GAIN_W'(ramp_step(speed_e'(mode), BSTEP));
    headroom = GAIN_W'(UNITY) - gain;
    if (mute)
      gain_next = (gain > step_amt) ? gain - step_amt : '0;
    else
      gain_next = (headroom > step_amt) ? gain + step_amt : GAIN_W'(UNITY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gain <= GAIN_W'(UNITY);
    else if (tick)
      gain <= gain_next;
  end

  assign at_zero = (gain == '0);

endmodule

// File: rtl/sm_chan_scale.sv
module sm_chan_scale #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [FRAC_W:0]          gain,
  output logic signed [DATA_W-1:0] scaled
);
  localparam int PW    = DATA_W + FRAC_W + 2;
  localparam int ROUND = 1 << (FRAC_W - 1);

  // Multiply by gain/2^FRAC_W, rounding half toward +infinity.
  function automatic logic signed [DATA_W-1:0] apply_gain(
    input logic signed [DATA_W-1:0] s,
    input logic [FRAC_W:0]          g
  );
    logic signed [PW-1:0] a, b, p, q;
    a = PW'(s);
    b = $signed(PW'({1'b0, g}));
    p = a * b + PW'(ROUND);
    q = p >>> FRAC_W;
    return q[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      scaled <= '0;
    else if (load)
      scaled <= apply_gain(sample, gain);
  end

endmodule

// File: rtl/softmute_ramp.sv
module softmute_ramp
  import softmute_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int FRAC_W       = 12,
  parameter int BASE_PERIODS = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mute_req,
  input  logic [1:0]               speed_mode,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     muted
);
  localparam int NCH    = 2;
  localparam int GAIN_W = FRAC_W + 1;
  localparam int UNITY  = 1 << FRAC_W;

  logic [GAIN_W-1:0]        gain_q;
  logic signed [DATA_W-1:0] ch_in  [NCH];
  logic signed [DATA_W-1:0] ch_out [NCH];

  // Named events for the checker.
  logic ramp_down_evt;
  logic ramp_up_evt;
  assign ramp_down_evt = in_valid &&  mute_req && (gain_q != '0);
  assign ramp_up_evt   = in_valid && !mute_req && (gain_q != GAIN_W'(UNITY));

  sm_gain_ramp #(
    .FRAC_W       (FRAC_W),
    .BASE_PERIODS (BASE_PERIODS)
  ) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (in_valid),
    .mute    (mute_req),
    .mode    (speed_mode),
    .gain    (gain_q),
    .at_zero (muted)
  );

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    sm_chan_scale #(
      .DATA_W (DATA_W),
      .FRAC_W (FRAC_W)
    ) u_scale (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (in_valid),
      .sample (ch_in[c]),
      .gain   (gain_q),
      .scaled (ch_out[c])
    );
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_valid <= 1'b0;
    else
      out_valid <= in_valid;
  end

endmodule

// File: rtl/softmute_ramp_chk.sv
module softmute_ramp_chk #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     mute_req,
  input logic [FRAC_W:0]          gain,
  input logic                     ramp_down_evt,
  input logic                     ramp_up_evt,
  input logic                     muted,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right
);
  localparam int UNITY = 1 << FRAC_W;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(gain) && $stable(out_left) && $stable(out_right));

  assert_descend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_down_evt |=> gain < $past(gain));

  assert_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_up_evt |=> gain > $past(gain));

  assert_strobe_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_zero_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain == '0) |=> (out_left == '0) && (out_right == '0));

  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(muted) |-> $past(in_valid) && $past(mute_req));

  assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= (FRAC_W+1)'(UNITY));

endmodule

bind softmute_ramp softmute_ramp_chk #(
  .DATA_W (DATA_W),
  .FRAC_W (FRAC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .mute_req      (mute_req),
  .gain          (gain_q),
  .ramp_down_evt (ramp_down_evt),
  .ramp_up_evt   (ramp_up_evt),
  .muted         (muted),
  .out_valid     (out_valid),
  .out_left      (out_left),
  .out_right     (out_right)
);

// File: tb/sim_softmute_ramp.sv
`timescale 1ns/1ps
module sim_softmute_ramp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mute_req = 1'b0;
  logic [1:0] speed_mode = 2'd0;
  logic in_valid = 1'b0;
  logic signed [23:0] in_left = '0;
  logic signed [23:0] in_right = '0;
  logic out_valid;
  logic signed [23:0] out_left, out_right;
  logic muted;

  always #2.5 clk = ~clk;

  softmute_ramp u0 (
    .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .speed_mode(speed_mode),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .muted(muted)
  );

  int n_chk = 0;
  int n_fail = 0;
  int gm = 4096;           // model gain
  string cur_tag = "R7";
  int exp_l[$];
  int exp_r[$];
  string tag_q[$];
  int last_l = 0;
  int last_r = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_scale(input int s, input int g);
    longint t;
    t = longint'(s) * longint'(g) + 64'sd2048;
    if (t >= 0) return int'(t / 4096);
    return -int'((-t + 4095) / 4096);
  endfunction

  function automatic int model_step(input logic [1:0] m);
    if (m == 2'd0) return 4;
    if (m == 2'd1) return 2;
    return 1;
  endfunction

  // Driver: one strobe, then one idle cycle.
  task automatic send(input int l, input int r);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = l[23:0];
    in_right = r[23:0];
    exp_l.push_back(model_scale(l, gm));
    exp_r.push_back(model_scale(r, gm));
    tag_q.push_back(cur_tag);
    if (mute_req) gm = (gm > model_step(speed_mode)) ? gm - model_step(speed_mode) : 0;
    else gm = (4096 - gm > model_step(speed_mode)) ? gm + model_step(speed_mode) : 4096;
    @(negedge clk);
    in_valid = 1'b0;
    chk(muted == (gm == 0), {cur_tag, "/R9 muted"}, int'(muted), int'(gm == 0));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      if (i % 3 == 2) send(-1234567 - i, 777 + i);
      else send(8388607, -8388608);
    end
  endtask

  // Monitor: compare each result strobe against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid) begin
          if (exp_l.size() == 0) begin
            chk(1'b0, "R7 unexpected out_valid", 1, 0);
          end else begin
            string t;
            int el, er;
            t = tag_q.pop_front();
            el = exp_l.pop_front();
            er = exp_r.pop_front();
            chk(int'(out_left) == el, {t, "/R7 left"}, int'(out_left), el);
            chk(int'(out_right) == er, {t, "/R7 right"}, int'(out_right), er);
          end
          last_l = int'(out_left);
          last_r = int'(out_right);
        end else begin
          chk(int'(out_left) == last_l && int'(out_right) == last_r,
              "R2 hold", int'(out_left), last_l);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(muted == 1'b0, "R1 muted", int'(muted), 0);
    chk(out_left == '0 && out_right == '0, "R1 outputs", int'(out_left), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && muted == 1'b0, "R1 after release", int'(muted), 0);

    // R8: bit-exact at unity, assorted patterns
    cur_tag = "R8";
    send(8388607, -8388608);
    send(1, -1);
    send(-3, 5);
    send(4660, -22136);
    // R10: extra releases at unity stay at unity
    cur_tag = "R10";
    run(4);

    // R2: request changes between strobes have no effect until a strobe
    cur_tag = "R2";
    mute_req = 1'b1;
    repeat (10) @(negedge clk);
    mute_req = 1'b0;
    repeat (3) @(negedge clk);
    send(8388607, -8388608);

    // R3: base-rate mute, 1024 strobes to zero
    cur_tag = "R3";
    speed_mode = 2'd0;
    mute_req = 1'b1;
    run(1023);
    chk(muted == 1'b0, "R3 not yet muted after 1023", int'(muted), 0);
    run(1);
    chk(muted == 1'b1, "R3 muted after 1024", int'(muted), 1);
    // R8 / R10: zero gain gives zero and stays there
    cur_tag = "R8";
    run(5);
    // R5: release at base rate
    cur_tag = "R5";
    mute_req = 1'b0;
    run(1030);

    // R4: double rate, 2048 strobes
    cur_tag = "R4";
    speed_mode = 2'd1;
    mute_req = 1'b1;
    run(2047);
    chk(muted == 1'b0, "R4 double not muted at 2047", int'(muted), 0);
    run(1);
    chk(muted == 1'b1, "R4 double muted at 2048", int'(muted), 1);
    // R6: reversal mid-way at double rate
    cur_tag = "R6";
    mute_req = 1'b0;
    run(700);
    mute_req = 1'b1;
    run(300);
    mute_req = 1'b0;
    run(2000);

    // R4: quad rate, 4096 strobes, then release
    cur_tag = "R4";
    speed_mode = 2'd2;
    mute_req = 1'b1;
    run(4095);
    chk(muted == 1'b0, "R4 quad not muted at 4095", int'(muted), 0);
    run(1);
    chk(muted == 1'b1, "R4 quad muted at 4096", int'(muted), 1);
    cur_tag = "R5";
    mute_req = 1'b0;
    run(4100);

    // R4: mode 3 behaves as quad; R10: mode switch near zero saturates
    cur_tag = "R4";
    speed_mode = 2'd3;
    mute_req = 1'b1;
    run(4093);
    cur_tag = "R10";
    speed_mode = 2'd0;
    run(3);
    chk(muted == 1'b1, "R10 saturate at zero on mode switch", int'(muted), 1);
    mute_req = 1'b0;
    run(1030);

    repeat (5) @(negedge clk);
    chk(exp_l.size() == 0, "R7 scoreboard drained", exp_l.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule